// File: doc/BRIEF.md
# Compare-Match Down-Counting Timer

This block is a 32-bit timer on a simple register bus. A free-running counter falls from all-ones toward zero, advancing once per prescaled tick. The tick comes from one of three tick-enable inputs, or from none. Software reads the counter and inverts it to get elapsed time. It can also program a compare value, so that an event is raised when the counter steps onto that value.

A compare event sets a sticky status flag, and software clears the flag by writing one to it. The event also drives an interrupt line when the interrupt is enabled, and acts on an output pin according to a two-bit action field. A reload option restarts the count from a programmed value after zero. An overwrite option makes each write of the reload value land in the counter at once. A self-clearing software reset returns the control, status, prescaler phase and pin to their initial state while keeping the reload and compare values.

Top module: `dtmr_top`

## Requirements
- R1: After reset, control, status, reload and compare read 0, the counter reads 0xFFFFFFFF, and irq_o and pin_o are 0.
- R2: Byte addresses are 0x00 control, 0x04 status, 0x08 reload, 0x0C compare and 0x10 counter. bus_rdata shows the addressed register in the same cycle that bus_re is high, and reads 0 for other addresses or when bus_re is low. Writes to 0x10 are ignored.
- R3: The control bits are en[0], irq_en[2], reload[3], prescale[15:4], overwrite[17], pin_action[23:22] and tick_sel[25:24]. They read back as written, and every other bit, bit 16 included, reads 0.
- R4: While en=1, the counter steps once every prescale+1 selected ticks. It steps at the clock edge where the final tick is sampled. It holds while en=0.
- R5: tick_sel chooses the tick: 0 no tick (the counter holds), 1 tick_periph, 2 tick_ref_hi, 3 tick_ref_lo.
- R6: A step from 0 loads the reload value when reload=1. With reload=0 the same step wraps the counter to 0xFFFFFFFF. Any other step subtracts 1.
- R7: Status bit 0 is set at the edge where a step makes the counter equal to the compare value. It stays set until a status write with bit 0 = 1. A write with bit 0 = 0 has no effect. When a set and a clear meet in one cycle, the set wins.
- R8: irq_o is high exactly while status bit 0 and irq_en are both 1. Clearing irq_en leaves the flag pending.
- R9: On a compare event, pin_o follows pin_action: 0 holds, 1 toggles, 2 drives 0, 3 drives 1. At no other time does pin_o change, except on reset.
- R10: With overwrite=1, a reload write also puts the written value into the counter at the next edge. With overwrite=0, the counter is untouched.
- R11: A control write with bit 16 = 1 clears control, status, prescaler phase and pin_o, and sets the counter to 0xFFFFFFFF, while reload and compare keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tick_periph | input | 1 | Tick enable, source 1 |
| tick_ref_hi | input | 1 | Tick enable, source 2 |
| tick_ref_lo | input | 1 | Tick enable, source 3 |
| irq_o | output | 1 | Compare interrupt |
| pin_o | output | 1 | Compare-driven output pin |

## Verification
A write takes effect at the edge that samples it, and read data is valid in the same cycle as bus_re. A step, the flag set it causes and the pin action all land on one edge, the one where the final prescaled tick is sampled. irq_o follows the flag with no added delay. The bench drives inputs on the falling edge. Its reference model advances on the rising edge from the same sampled inputs, and irq_o and pin_o are compared on every falling edge. Read data is checked 1 ns after the falling edge that presents the address. Any error in latency therefore shows up as a mismatch in a specific cycle.

// File: rtl/dtmr_pkg.sv
// Package: shared constants and types for the down-counting timer.
// Assumes a 32-bit data bus; field positions below are the control layout.
package dtmr_pkg;
    localparam int DTMR_DW    = 32;
    localparam int DTMR_PW    = 12;
    localparam int DTMR_AW    = 5;

    localparam logic [DTMR_AW-1:0] A_CTRL = 5'h00;
    localparam logic [DTMR_AW-1:0] A_STAT = 5'h04;
    localparam logic [DTMR_AW-1:0] A_LOAD = 5'h08;
    localparam logic [DTMR_AW-1:0] A_CMP  = 5'h0C;
    localparam logic [DTMR_AW-1:0] A_CNT  = 5'h10;

    localparam int B_EN    = 0;
    localparam int B_IEN   = 2;
    localparam int B_RLD   = 3;
    localparam int B_PRE_L = 4;
    localparam int B_SWR   = 16;
    localparam int B_OVW   = 17;
    localparam int B_OM_L  = 22;
    localparam int B_SRC_L = 24;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_LOW    = 2'd2,
        PIN_HIGH   = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_PERIPH = 2'd1,
        SRC_HI     = 2'd2,
        SRC_LO     = 2'd3
    } tick_src_e;

    typedef struct packed {
        tick_src_e           src;
        pin_act_e            omode;
        logic                ovw;
        logic [DTMR_PW-1:0]  presc;
        logic                rld;
        logic                ien;
        logic                en;
    } ctrl_t;
endpackage

// File: rtl/dtmr_regs.sv
// Register file: control, status flag, reload and compare registers,
// write decode (software reset, overwrite, flag clear) and read mux.
// Assumes the counter value and compare event come from dtmr_count.
module dtmr_regs
    import dtmr_pkg::*;
#(
    parameter int DW = DTMR_DW,
    parameter int PW = DTMR_PW,
    parameter int AW = DTMR_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt,
    input  logic          match_ev,
    output logic [DW-1:0] rdata,
    output logic          en,
    output logic          ien,
    output logic          rld,
    output logic [PW-1:0] presc,
    output pin_act_e      omode,
    output tick_src_e     src,
    output logic [DW-1:0] load_q,
    output logic [DW-1:0] cmp_q,
    output logic          flag_q,
    output logic          swr,
    output logic          ovw_wr,
    output logic          flag_clr
);
    ctrl_t         ctrl_q;
    logic          ctrl_we;
    logic          load_we;
    logic          cmp_we;
    logic [DW-1:0] ctrl_word;
    logic [DW-1:0] rd_mux;

    // Decode the write strobes per register.
    always_comb begin
        ctrl_we  = we && (addr == A_CTRL);
        load_we  = we && (addr == A_LOAD);
        cmp_we   = we && (addr == A_CMP);
        swr      = ctrl_we && wdata[B_SWR];
        ovw_wr   = load_we && ctrl_q.ovw;
        flag_clr = we && (addr == A_STAT) && wdata[0];
    end

    // Control register; a software reset overrides the written value.
    always_ff @(posedge clk) begin
        if (!rst_n || swr) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.en    <= wdata[B_EN];
            ctrl_q.ien   <= wdata[B_IEN];
            ctrl_q.rld   <= wdata[B_RLD];
            ctrl_q.presc <= wdata[B_PRE_L +: PW];
            ctrl_q.ovw   <= wdata[B_OVW];
            ctrl_q.omode <= pin_act_e'(wdata[B_OM_L +: 2]);
            ctrl_q.src   <= tick_src_e'(wdata[B_SRC_L +: 2]);
        end
    end

    // Reload and compare registers; untouched by software reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (load_we) load_q <= wdata;
            if (cmp_we)  cmp_q  <= wdata;
        end
    end

    // Sticky compare flag: reset beats set, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n || swr)  flag_q <= 1'b0;
        else if (match_ev)  flag_q <= 1'b1;
        else if (flag_clr)  flag_q <= 1'b0;
    end

    // Pack control fields back into the bus layout.
    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[B_EN]             = ctrl_q.en;
        ctrl_word[B_IEN]            = ctrl_q.ien;
        ctrl_word[B_RLD]            = ctrl_q.rld;
        ctrl_word[B_PRE_L +: PW]    = ctrl_q.presc;
        ctrl_word[B_OVW]            = ctrl_q.ovw;
        ctrl_word[B_OM_L +: 2]      = ctrl_q.omode;
        ctrl_word[B_SRC_L +: 2]     = ctrl_q.src;
    end

    // Read multiplexer, gated by the read strobe.
    always_comb begin
        unique case (addr)
            A_CTRL:  rd_mux = ctrl_word;
            A_STAT:  rd_mux = {{(DW-1){1'b0}}, flag_q};
            A_LOAD:  rd_mux = load_q;
            A_CMP:   rd_mux = cmp_q;
            A_CNT:   rd_mux = cnt;
            default: rd_mux = '0;
        endcase
        rdata = re ? rd_mux : '0;
    end

    // Expose fields to the datapath.
    always_comb begin
        en    = ctrl_q.en;
        ien   = ctrl_q.ien;
        rld   = ctrl_q.rld;
        presc = ctrl_q.presc;
        omode = ctrl_q.omode;
        src   = ctrl_q.src;
    end
endmodule

// File: rtl/dtmr_prescale.sv
// Tick selection and prescaler: emits one step per (presc+1) selected ticks.
// Assumes tick inputs are synchronous one-cycle enables.
module dtmr_prescale
    import dtmr_pkg::*;
#(
    parameter int PW = DTMR_PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swr,
    input  logic          en,
    input  tick_src_e     src,
    input  logic [PW-1:0] presc,
    input  logic          tick_periph,
    input  logic          tick_ref_hi,
    input  logic          tick_ref_lo,
    output logic          step
);
    logic [3:0]    tick_vec;
    logic          tick_sel;
    logic [PW-1:0] phase_q;

    // Pick the tick source; code 0 is a dead input.
    always_comb begin
        tick_vec = {tick_ref_lo, tick_ref_hi, tick_periph, 1'b0};
        tick_sel = tick_vec[src];
        step     = en && tick_sel && (phase_q >= presc);
    end

    // Prescaler phase counts selected ticks up to presc.
    always_ff @(posedge clk) begin
        if (!rst_n || swr)        phase_q <= '0;
        else if (en && tick_sel)  phase_q <= step ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/dtmr_count.sv
// Down counter with reload/wrap, immediate overwrite, compare event and pin
// action. Assumes at most one of swr/ovw is set per cycle (distinct addresses).
module dtmr_count
    import dtmr_pkg::*;
#(
    parameter int DW = DTMR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swr,
    input  logic          step,
    input  logic          ovw,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] load,
    input  logic [DW-1:0] cmp,
    input  logic          rld,
    input  pin_act_e      omode,
    output logic [DW-1:0] cnt_q,
    output logic          match_ev,
    output logic          pin_q
);
    logic [DW-1:0] cnt_nx;

    // Next value after one step, and whether it lands on compare.
    always_comb begin
        cnt_nx   = (rld && (cnt_q == '0)) ? load : cnt_q - 1'b1;
        match_ev = step && !swr && !ovw && (cnt_nx == cmp);
    end

    // Counter: reset, then overwrite, then step.
    always_ff @(posedge clk) begin
        if (!rst_n || swr) cnt_q <= '1;
        else if (ovw)      cnt_q <= wdata;
        else if (step)     cnt_q <= cnt_nx;
    end

    // Output pin action on each compare event.
    always_ff @(posedge clk) begin
        if (!rst_n || swr) begin
            pin_q <= 1'b0;
        end else if (match_ev) begin
            unique case (omode)
                PIN_TOGGLE: pin_q <= ~pin_q;
                PIN_LOW:    pin_q <= 1'b0;
                PIN_HIGH:   pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end
    end
endmodule

// File: rtl/dtmr_top.sv
// Top of the compare-match down-counting timer: ties register file,
// prescaler and counter together. Assumes a single clock domain.
module dtmr_top
    import dtmr_pkg::*;
#(
    parameter int DW = DTMR_DW,
    parameter int PW = DTMR_PW,
    parameter int AW = DTMR_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_periph,
    input  logic          tick_ref_hi,
    input  logic          tick_ref_lo,
    output logic          irq_o,
    output logic          pin_o
);
    logic          en, ien, rld, stat_flag, swr_pulse, load_ovw, flag_clr;
    logic          cnt_step, match_ev;
    logic [PW-1:0] presc;
    pin_act_e      omode;
    tick_src_e     src;
    logic [DW-1:0] load_q, cmp_q, cnt_q;

    dtmr_regs #(.DW(DW), .PW(PW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .re(bus_re),
        .addr(bus_addr), .wdata(bus_wdata), .cnt(cnt_q), .match_ev(match_ev),
        .rdata(bus_rdata), .en(en), .ien(ien), .rld(rld), .presc(presc),
        .omode(omode), .src(src), .load_q(load_q), .cmp_q(cmp_q),
        .flag_q(stat_flag), .swr(swr_pulse), .ovw_wr(load_ovw),
        .flag_clr(flag_clr)
    );

    dtmr_prescale #(.PW(PW)) u_pre (
        .clk(clk), .rst_n(rst_n), .swr(swr_pulse), .en(en), .src(src),
        .presc(presc), .tick_periph(tick_periph), .tick_ref_hi(tick_ref_hi),
        .tick_ref_lo(tick_ref_lo), .step(cnt_step)
    );

    dtmr_count #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .swr(swr_pulse), .step(cnt_step),
        .ovw(load_ovw), .wdata(bus_wdata), .load(load_q), .cmp(cmp_q),
        .rld(rld), .omode(omode), .cnt_q(cnt_q), .match_ev(match_ev),
        .pin_q(pin_o)
    );

    // Interrupt: pending flag qualified by its enable.
    always_comb irq_o = stat_flag && ien;
endmodule

// File: rtl/dtmr_chk.sv
// Checker bound to dtmr_top: temporal properties of counter, flag and pin.
module dtmr_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          swr,
    input logic          ovw,
    input logic          rld,
    input logic [DW-1:0] cnt,
    input logic          flag,
    input logic          clr,
    input logic          match_ev,
    input logic          pin
);
    AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !swr && !ovw && !(rld && cnt == '0)) |=> (cnt == $past(cnt) - 1'b1)); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !swr && !ovw) |=> $stable(cnt)); // R4
    AST_SWR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> (cnt == '1 && !flag && !pin)); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !swr) |=> flag); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (match_ev && !swr) |=> flag); // R7
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_ev && !swr) |=> $stable(pin)); // R9
endmodule

bind dtmr_top dtmr_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(cnt_step), .swr(swr_pulse),
    .ovw(load_ovw), .rld(rld), .cnt(cnt_q), .flag(stat_flag),
    .clr(flag_clr), .match_ev(match_ev), .pin(pin_o)
);

// File: tb/sim_dtmr_top.sv
module sim_dtmr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_periph = 1'b1, tick_ref_hi = 1'b0, tick_ref_lo = 1'b0;
    logic        irq_o, pin_o;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;
    bit          live = 1'b0;
    int          tcnt = 0;

    dtmr_top u0 (.*);

    always #5 clk = ~clk;

    // Reference model state
    bit [31:0] m_ctrl, m_cnt, m_load, m_cmp;
    bit        m_flag, m_pin;
    int        m_phase;

    function automatic bit [31:0] mk(bit en, bit ien, bit rld, bit [11:0] pre,
                                     bit ovw, bit [1:0] om, bit [1:0] src);
        return (32'(en)) | (32'(ien) << 2) | (32'(rld) << 3) | (32'(pre) << 4)
             | (32'(ovw) << 17) | (32'(om) << 22) | (32'(src) << 24);
    endfunction

    function automatic bit [31:0] mread(bit [4:0] a);
        case (a)
            5'h00: return m_ctrl;
            5'h04: return {31'b0, m_flag};
            5'h08: return m_load;
            5'h0C: return m_cmp;
            5'h10: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    // Behavioural model, advanced on each rising edge from sampled inputs.
    always @(posedge clk) begin
        bit sel, step, swr, ovw, clr, match;
        bit [31:0] n;
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 32'hFFFF_FFFF; m_load = 0; m_cmp = 0;
            m_flag = 0; m_pin = 0; m_phase = 0;
        end else begin
            case (m_ctrl[25:24])
                2'd1: sel = tick_periph;
                2'd2: sel = tick_ref_hi;
                2'd3: sel = tick_ref_lo;
                default: sel = 0;
            endcase
            step  = m_ctrl[0] && sel && (m_phase >= int'(m_ctrl[15:4]));
            swr   = bus_we && bus_addr == 5'h00 && bus_wdata[16];
            ovw   = bus_we && bus_addr == 5'h08 && m_ctrl[17];
            clr   = bus_we && bus_addr == 5'h04 && bus_wdata[0];
            match = 0;
            if (swr) begin
                m_ctrl = 0; m_flag = 0; m_phase = 0; m_cnt = 32'hFFFF_FFFF; m_pin = 0;
            end else begin
                if (m_ctrl[0] && sel) m_phase = step ? 0 : m_phase + 1;
                if (ovw) m_cnt = bus_wdata;
                else if (step) begin
                    n = (m_ctrl[3] && m_cnt == 0) ? m_load : m_cnt - 1;
                    match = (n == m_cmp);
                    m_cnt = n;
                end
                if (match) begin
                    case (m_ctrl[23:22])
                        2'd1: m_pin = ~m_pin;
                        2'd2: m_pin = 0;
                        2'd3: m_pin = 1;
                        default: ;
                    endcase
                end
                if (match) m_flag = 1;
                else if (clr) m_flag = 0;
                if (bus_we && bus_addr == 5'h00) m_ctrl = bus_wdata & 32'h03C2_FFFD;
                if (bus_we && bus_addr == 5'h08) m_load = bus_wdata;
                if (bus_we && bus_addr == 5'h0C) m_cmp = bus_wdata;
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Tick pattern: periph every cycle, hi every 2nd, lo every 3rd.
    always @(negedge clk) begin
        tcnt++;
        tick_ref_hi <= (tcnt % 2) == 0;
        tick_ref_lo <= (tcnt % 3) == 0;
    end

    // Per-cycle comparison of the outputs against the model.
    always @(negedge clk) begin
        if (live) begin
            chk({31'b0, irq_o}, {31'b0, m_flag && m_ctrl[2]}, "R8 irq");
            chk({31'b0, pin_o}, {31'b0, m_pin}, "R9 pin");
        end
    end

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_re = 0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 0; bus_re = 0;
        end
    endtask

    task automatic rd(input bit [4:0] a, input string tag, output logic [31:0] v);
        @(negedge clk);
        bus_we = 0; bus_re = 1; bus_addr = a;
        #1;
        v = bus_rdata;
        chk(bus_rdata, mread(a), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        live = 1;
        // R1 reset values
        rd(5'h00, "R1 ctrl", v);  chk(v, 0, "R1 ctrl");
        rd(5'h04, "R1 stat", v);  chk(v, 0, "R1 stat");
        rd(5'h08, "R1 load", v);
        rd(5'h0C, "R1 cmp", v);
        rd(5'h10, "R1 cnt", v);   chk(v, 32'hFFFF_FFFF, "R1 cnt");
        rd(5'h14, "R2 unmapped", v); chk(v, 0, "R2 unmapped");
        @(negedge clk); bus_re = 0; bus_addr = 5'h10; #1;
        chk(bus_rdata, 0, "R2 re low");
        // R3 field readback
        wr(5'h00, mk(0, 1, 1, 12'hABC, 1, 2, 3) | 32'hFC00_0000);
        rd(5'h00, "R3 ctrl", v); chk(v, 32'h0382_ABCC, "R3 ctrl");
        // R10 overwrite
        wr(5'h08, 32'h40);
        rd(5'h10, "R10 ovw on", v); chk(v, 32'h40, "R10 ovw on");
        wr(5'h00, mk(0, 0, 0, 0, 0, 0, 1));
        wr(5'h08, 32'h99);
        rd(5'h10, "R10 ovw off", v); chk(v, 32'h40, "R10 ovw off");
        // R2 counter read-only
        wr(5'h10, 32'h1234);
        rd(5'h10, "R2 cnt ro", v); chk(v, 32'h40, "R2 cnt ro");
        // R4 prescaler
        wr(5'h00, mk(1, 0, 0, 0, 0, 0, 1));
        idle(5); rd(5'h10, "R4 presc0", v);
        wr(5'h00, mk(1, 0, 0, 3, 0, 0, 1));
        idle(12); rd(5'h10, "R4 presc3", v);
        // R5 tick select
        wr(5'h00, mk(1, 0, 0, 0, 0, 0, 0));
        rd(5'h10, "R5 none", v); idle(5); rd(5'h10, "R5 none", v2);
        chk(v2, v, "R5 none hold");
        wr(5'h00, mk(1, 0, 0, 0, 0, 0, 2)); idle(7); rd(5'h10, "R5 hi", v);
        wr(5'h00, mk(1, 0, 0, 0, 0, 0, 3)); idle(7); rd(5'h10, "R5 lo", v);
        // R6 reload and wrap
        wr(5'h00, mk(0, 0, 0, 0, 1, 0, 1));
        wr(5'h08, 32'd3);
        wr(5'h00, mk(1, 0, 1, 0, 0, 0, 1));
        idle(2); rd(5'h10, "R6 rld", v);
        idle(3); rd(5'h10, "R6 rld", v);
        wr(5'h00, mk(0, 0, 0, 0, 1, 0, 1));
        wr(5'h08, 32'd1);
        wr(5'h00, mk(1, 0, 0, 0, 0, 0, 1));
        idle(2); rd(5'h10, "R6 wrap", v);
        // R7 / R8 compare flag and interrupt
        wr(5'h00, mk(0, 0, 0, 0, 1, 0, 1));
        wr(5'h0C, 32'd50);
        wr(5'h08, 32'd53);
        wr(5'h04, 32'd1);
        wr(5'h00, mk(1, 1, 0, 0, 0, 1, 1));
        idle(6);
        rd(5'h04, "R7 set", v); chk(v, 1, "R7 set");
        chk({31'b0, irq_o}, 1, "R8 irq high");
        wr(5'h00, mk(0, 0, 0, 0, 0, 1, 1));
        rd(5'h04, "R8 pending", v); chk(v, 1, "R8 pending");
        chk({31'b0, irq_o}, 0, "R8 irq masked");
        wr(5'h04, 32'd0);
        rd(5'h04, "R7 w0", v); chk(v, 1, "R7 w0");
        wr(5'h04, 32'd1);
        rd(5'h04, "R7 w1c", v); chk(v, 0, "R7 w1c");
        // R7 set wins over clear in the same cycle
        wr(5'h00, mk(0, 0, 0, 0, 1, 0, 1));
        wr(5'h08, 32'd51);
        wr(5'h00, mk(1, 0, 0, 0, 1, 0, 1));
        wr(5'h04, 32'd1);
        rd(5'h04, "R7 set wins", v); chk(v, 1, "R7 set wins");
        // R9 pin actions: low, high, keep, toggle
        for (int k = 0; k < 4; k++) begin
            bit [1:0] om;
            bit       pexp;
            om   = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 0 : 1;
            pexp = (k == 1 || k == 2);
            wr(5'h00, mk(0, 0, 0, 0, 1, om, 1));
            wr(5'h08, 32'd51);
            wr(5'h00, mk(1, 0, 0, 0, 1, om, 1));
            idle(3);
            chk({31'b0, pin_o}, {31'b0, pexp}, "R9 pin action");
        end
        // R11 software reset
        wr(5'h00, mk(0, 0, 0, 0, 1, 3, 1));
        wr(5'h08, 32'h77);
        wr(5'h0C, 32'h55);
        wr(5'h00, 32'h0001_0001 | mk(0, 1, 0, 5, 0, 3, 1));
        rd(5'h00, "R11 ctrl", v); chk(v, 0, "R11 ctrl");
        rd(5'h04, "R11 stat", v); chk(v, 0, "R11 stat");
        rd(5'h10, "R11 cnt", v);  chk(v, 32'hFFFF_FFFF, "R11 cnt");
        rd(5'h08, "R11 load", v); chk(v, 32'h77, "R11 load");
        rd(5'h0C, "R11 cmp", v);  chk(v, 32'h55, "R11 cmp");
        chk({31'b0, pin_o}, 0, "R11 pin");
        idle(3);
        live = 0;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule